// File: doc/BRIEF.md
# CCD Line Readout Blanking Sequencer

This block times the readout of a CCD sensor. It runs on the pixel clock. It counts pixels within each line from the rising edge of a horizontal sync input, and lines within each frame from the rising edge of a vertical sync input. Every line is divided into five consecutive pixel regions: a vertical-shift interval, dummy pixels, leading optical-black pixels, effective pixels and trailing optical-black pixels. Every frame is divided into leading black lines, effective lines and trailing black lines.

From these counts the block drives three active-high windows. The first keeps the horizontal clocks blanked during the vertical shift. The second is a clamp window that tells the analog front end when it sees optical black. The third is an optional pixel-blanking window that suppresses the digital output on non-image pixels. Black lines can use an alternative window sequence that holds the clamp for the whole line. The block also reports the current line region and the pixel index.

Region sizes and the two sequence selections are written through a simple write port into shadow registers. They become active together on the next vertical sync, so a frame never mixes two configurations.

Top module: `ccd_line_sequencer`

## Requirements
- R1: A rising edge of `hSync` sampled at clock edge E restarts the line. `pixIndex` reads 0 after edge E+1 and then rises by one on every clock. The windows and `lineRegion` are registered and aligned with `pixIndex`. A level held high does not restart the line again.
- R2: Pixel regions follow in this fixed order from index 0: vertical shift (size at address 0), dummy (address 1), leading black (address 2), effective (address 3), trailing black (address 4). On a line that uses the normal sequence, `hClkBlank` is high exactly over the vertical shift and `clampWin` is high exactly over the trailing black pixels. When pixel blanking is enabled, `pixBlank` is high over the vertical shift, dummy, leading black and trailing black pixels.
- R3: Bit 0 of the control register (address 7) enables pixel blanking. While that bit is 0 in the active configuration, `pixBlank` stays low.
- R4: Bit 1 of the control register selects the black-line sequence. When it is set, lines in the leading or trailing black regions hold `clampWin` high from the first dummy pixel through the last trailing black pixel. `hClkBlank` and `pixBlank` are unchanged on those lines.
- R5: When bit 1 of the control register is clear, black lines use exactly the same windows as effective lines.
- R6: All three windows are low on pixels past the end of the trailing black region, up to the next line start. They are also low after reset until the first line start.
- R7: A line that is cut short by a new `hSync` edge restarts at pixel 0 under the new line's timing. No window of the old line continues into the new one.
- R8: `lineRegion` encodes 0 for leading black, 1 for effective and 2 for trailing black. The first line start after a `vSync` rising edge is line 0. Lines below the leading-line count (address 5) are leading black. The next lines, up to the effective-line count (address 6), are effective. All later lines are trailing black.
- R9: A write with `cfgWe` high stores the low bits of `cfgData` into the shadow copy of the register at `cfgAddr`. All shadow values are copied to the active configuration on a `vSync` rising edge, and at no other time.
- R10: While `rstN` is low, all outputs are 0 and the active and shadow configurations hold the parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| hSync | input | 1 | Horizontal sync; rising edge starts a line |
| vSync | input | 1 | Vertical sync; rising edge starts a frame and applies the configuration |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgData | input | DATA_W | Configuration write data |
| clampWin | output | 1 | Clamp window |
| pixBlank | output | 1 | Digital output blanking window |
| hClkBlank | output | 1 | Horizontal clock blanking window |
| lineRegion | output | 2 | Current line region code |
| pixIndex | output | PIX_W | Current pixel index within the line |

## Verification
The bench builds the block with an 8-bit pixel counter, a 6-bit line counter and region sizes of a few pixels each. A line of 20 clocks therefore covers every pixel region plus an idle tail, and a frame of seven lines covers all three line regions. Every pixel of every line is compared with a model computed from the region sizes. The bench covers three configurations, with both sequence selections and pixel blanking on and off. It also runs a frame of deliberately shortened lines, and one line under the default configuration while new values wait in the shadow registers.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  // Line region code driven on the lineRegion output
  typedef enum logic [1:0] {
    LR_LEAD_BLACK  = 2'd0,
    LR_EFFECTIVE   = 2'd1,
    LR_TRAIL_BLACK = 2'd2
  } lineRegion_e;

  // Position of the pixel counter within a line
  typedef enum logic [2:0] {
    PR_VSHIFT,
    PR_DUMMY,
    PR_LEAD,
    PR_EFF,
    PR_TRAIL,
    PR_IDLE
  } pixRegion_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic        lineStart;
    logic        useBlackSeq;
    lineRegion_e lineRegion;
  } seqStrobes_t;

  // Pixel fields, in line order, occupy addresses 0..NUM_PIX_FIELDS-1
  localparam int NUM_PIX_FIELDS  = 5;
  localparam int F_VSHIFT        = 0;
  localparam int F_DUMMY         = 1;
  localparam int F_LEAD          = 2;
  localparam int F_EFF           = 3;
  localparam int F_TRAIL         = 4;
  // Line fields follow the pixel fields
  localparam int NUM_LINE_FIELDS = 2;
  localparam int LINE_BASE       = NUM_PIX_FIELDS;
  localparam int FL_LEAD         = 0;
  localparam int FL_EFF          = 1;
  localparam logic [2:0] ADDR_CTRL = 3'd7;

endpackage

// File: rtl/ccd_seq_regs.sv
module ccd_seq_regs
  import ccd_seq_pkg::*;
#(
  parameter int PIX_W          = 12,
  parameter int LINE_W         = 11,
  parameter int DATA_W         = 16,
  parameter int DEF_VSHIFT     = 16,
  parameter int DEF_DUMMY      = 28,
  parameter int DEF_LEAD_PIX   = 4,
  parameter int DEF_EFF_PIX    = 1280,
  parameter int DEF_TRAIL_PIX  = 48,
  parameter int DEF_LEAD_LINES = 10,
  parameter int DEF_EFF_LINES  = 960,
  parameter bit DEF_PB_EN      = 1'b1,
  parameter bit DEF_BLACK_SEQ  = 1'b0
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   cfgWe,
  input  logic [2:0]                             cfgAddr,
  input  logic [DATA_W-1:0]                      cfgData,
  input  logic                                   frameStart,
  output logic [NUM_PIX_FIELDS-1:0][PIX_W-1:0]   activePix,
  output logic [NUM_LINE_FIELDS-1:0][LINE_W-1:0] activeLines,
  output logic                                   activePbEn,
  output logic                                   activeBlackSeq
);

  logic [NUM_PIX_FIELDS-1:0][PIX_W-1:0]   shadowPix;
  logic [NUM_LINE_FIELDS-1:0][LINE_W-1:0] shadowLines;
  logic                                   shadowPbEn;
  logic                                   shadowBlackSeq;
  logic                                   unusedCfgBits;

  assign unusedCfgBits = ^cfgData[DATA_W-1:2];

  function automatic logic [PIX_W-1:0] pixDefault(input int idx);
    case (idx)
      F_VSHIFT: return PIX_W'(DEF_VSHIFT);
      F_DUMMY:  return PIX_W'(DEF_DUMMY);
      F_LEAD:   return PIX_W'(DEF_LEAD_PIX);
      F_EFF:    return PIX_W'(DEF_EFF_PIX);
      default:  return PIX_W'(DEF_TRAIL_PIX);
    endcase
  endfunction

  function automatic logic [LINE_W-1:0] lineDefault(input int idx);
    return (idx == FL_LEAD) ? LINE_W'(DEF_LEAD_LINES) : LINE_W'(DEF_EFF_LINES);
  endfunction

  for (genvar g = 0; g < NUM_PIX_FIELDS; g++) begin : gPixField
    logic [PIX_W-1:0] shadowQ;
    logic [PIX_W-1:0] activeQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowQ <= pixDefault(g);
        activeQ <= pixDefault(g);
      end else begin
        if (cfgWe && cfgAddr == 3'(g)) shadowQ <= cfgData[PIX_W-1:0];
        if (frameStart) activeQ <= shadowQ;
      end
    end
    assign shadowPix[g] = shadowQ;
    assign activePix[g] = activeQ;
  end

  for (genvar g = 0; g < NUM_LINE_FIELDS; g++) begin : gLineField
    logic [LINE_W-1:0] shadowQ;
    logic [LINE_W-1:0] activeQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowQ <= lineDefault(g);
        activeQ <= lineDefault(g);
      end else begin
        if (cfgWe && cfgAddr == 3'(LINE_BASE + g)) shadowQ <= cfgData[LINE_W-1:0];
        if (frameStart) activeQ <= shadowQ;
      end
    end
    assign shadowLines[g] = shadowQ;
    assign activeLines[g] = activeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowPbEn     <= DEF_PB_EN;
      shadowBlackSeq <= DEF_BLACK_SEQ;
      activePbEn     <= DEF_PB_EN;
      activeBlackSeq <= DEF_BLACK_SEQ;
    end else begin
      if (cfgWe && cfgAddr == ADDR_CTRL) begin
        shadowPbEn     <= cfgData[0];
        shadowBlackSeq <= cfgData[1];
      end
      if (frameStart) begin
        activePbEn     <= shadowPbEn;
        activeBlackSeq <= shadowBlackSeq;
      end
    end
  end

  // R9: the active set changes only on a frame start
  a_r9_active_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> ($stable(activePix) && $stable(activeLines) &&
                     $stable(activePbEn) && $stable(activeBlackSeq)))
    else $error("R9 active configuration changed without frame start");

  // R9: a frame start takes over the shadow values
  a_r9_shadow_copy: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (activePix == $past(shadowPix)) && (activeLines == $past(shadowLines)) &&
                   (activePbEn == $past(shadowPbEn)) && (activeBlackSeq == $past(shadowBlackSeq)))
    else $error("R9 shadow values not applied on frame start");

endmodule

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSync,
  input  logic              vSync,
  input  logic [LINE_W-1:0] leadLines,
  input  logic [LINE_W-1:0] effLines,
  input  logic              blackSeqEn,
  output logic              frameStart,
  output seqStrobes_t       strobes
);

  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic              hsPrev;
  logic              vsPrev;
  logic              lineEdge;
  logic              firstPending;
  logic [LINE_W-1:0] lineCnt;
  logic [LINE_W:0]   effEnd;
  lineRegion_e       curRegion;

  assign lineEdge   = hSync & ~hsPrev;
  assign frameStart = vSync & ~vsPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsPrev <= 1'b0;
      vsPrev <= 1'b0;
    end else begin
      hsPrev <= hSync;
      vsPrev <= vSync;
    end
  end

  // Line counter; the first line start after a frame start is line 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt      <= '0;
      firstPending <= 1'b1;
    end else if (frameStart) begin
      lineCnt      <= '0;
      firstPending <= ~lineEdge;
    end else if (lineEdge) begin
      if (firstPending) begin
        firstPending <= 1'b0;
      end else if (lineCnt != LINE_MAX) begin
        lineCnt <= lineCnt + LINE_W'(1);
      end
    end
  end

  assign effEnd = (LINE_W+1)'(leadLines) + (LINE_W+1)'(effLines);

  always_comb begin
    if (lineCnt < leadLines)                 curRegion = LR_LEAD_BLACK;
    else if ((LINE_W+1)'(lineCnt) < effEnd)  curRegion = LR_EFFECTIVE;
    else                                     curRegion = LR_TRAIL_BLACK;
  end

  assign strobes.lineStart   = lineEdge;
  assign strobes.lineRegion  = curRegion;
  assign strobes.useBlackSeq = blackSeqEn && (curRegion != LR_EFFECTIVE);

  // R8: a frame start returns the count to line 0
  a_r8_frame_restart: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (lineCnt == '0))
    else $error("R8 line count not cleared by frame start");

  // R8: later line starts advance the count by one
  a_r8_line_advance: assert property (@(posedge clk) disable iff (!rstN)
    (lineEdge && !frameStart && !firstPending && lineCnt != LINE_MAX)
      |=> (lineCnt == $past(lineCnt) + LINE_W'(1)))
    else $error("R8 line count did not advance");

endmodule

// File: rtl/ccd_seq_datapath.sv
module ccd_seq_datapath
  import ccd_seq_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  seqStrobes_t                          strobes,
  input  logic [NUM_PIX_FIELDS-1:0][PIX_W-1:0] activePix,
  input  logic                                 pbEn,
  output logic                                 clampWin,
  output logic                                 pixBlank,
  output logic                                 hClkBlank,
  output logic [1:0]                           lineRegion,
  output logic [PIX_W-1:0]                     pixIndex
);

  localparam int              SUM_W   = PIX_W + 3;
  localparam logic [PIX_W-1:0] PIX_MAX = {PIX_W{1'b1}};

  logic [PIX_W-1:0] pixCnt;
  logic [SUM_W-1:0] regionEnd [NUM_PIX_FIELDS];
  pixRegion_e       curPix;
  logic             nxtClamp;
  logic             nxtBlank;
  logic             nxtHBlank;

  // Pixel counter restarts on a line start and rests at its maximum
  always_ff @(posedge clk) begin
    if (!rstN)                  pixCnt <= PIX_MAX;
    else if (strobes.lineStart) pixCnt <= '0;
    else if (pixCnt != PIX_MAX) pixCnt <= pixCnt + PIX_W'(1);
  end

  // Running end position of each region
  always_comb begin
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_PIX_FIELDS; i++) begin
      acc          = acc + SUM_W'(activePix[i]);
      regionEnd[i] = acc;
    end
  end

  // Earliest region whose end lies beyond the counter wins
  always_comb begin
    curPix = PR_IDLE;
    if (SUM_W'(pixCnt) < regionEnd[F_TRAIL])  curPix = PR_TRAIL;
    if (SUM_W'(pixCnt) < regionEnd[F_EFF])    curPix = PR_EFF;
    if (SUM_W'(pixCnt) < regionEnd[F_LEAD])   curPix = PR_LEAD;
    if (SUM_W'(pixCnt) < regionEnd[F_DUMMY])  curPix = PR_DUMMY;
    if (SUM_W'(pixCnt) < regionEnd[F_VSHIFT]) curPix = PR_VSHIFT;
  end

  always_comb begin
    nxtHBlank = (curPix == PR_VSHIFT);
    nxtBlank  = pbEn && (curPix inside {PR_VSHIFT, PR_DUMMY, PR_LEAD, PR_TRAIL});
    if (strobes.useBlackSeq) nxtClamp = curPix inside {PR_DUMMY, PR_LEAD, PR_EFF, PR_TRAIL};
    else                     nxtClamp = (curPix == PR_TRAIL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clampWin   <= 1'b0;
      pixBlank   <= 1'b0;
      hClkBlank  <= 1'b0;
      lineRegion <= 2'd0;
      pixIndex   <= '0;
    end else begin
      clampWin   <= nxtClamp;
      pixBlank   <= nxtBlank;
      hClkBlank  <= nxtHBlank;
      lineRegion <= strobes.lineRegion;
      pixIndex   <= pixCnt;
    end
  end

  // R1: a line start clears the pixel counter on the next edge
  a_r1_line_restart: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lineStart |=> (pixCnt == '0))
    else $error("R1 pixel counter not cleared");

  // R2: clamp never overlaps the vertical shift blanking
  a_r2_shift_clamp_apart: assert property (@(posedge clk) disable iff (!rstN)
    !(hClkBlank && clampWin))
    else $error("R2 clamp during vertical shift");

  // R3: pixel blanking stays off while disabled
  a_r3_blank_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !pbEn |=> !pixBlank)
    else $error("R3 pixel blanking while disabled");

  // R6: nothing is open after the last region
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (curPix == PR_IDLE) |=> !(clampWin || pixBlank || hClkBlank))
    else $error("R6 window open past line end");

endmodule

// File: rtl/ccd_line_sequencer.sv
module ccd_line_sequencer
  import ccd_seq_pkg::*;
#(
  parameter int PIX_W          = 12,
  parameter int LINE_W         = 11,
  parameter int DATA_W         = 16,
  parameter int DEF_VSHIFT     = 16,
  parameter int DEF_DUMMY      = 28,
  parameter int DEF_LEAD_PIX   = 4,
  parameter int DEF_EFF_PIX    = 1280,
  parameter int DEF_TRAIL_PIX  = 48,
  parameter int DEF_LEAD_LINES = 10,
  parameter int DEF_EFF_LINES  = 960,
  parameter bit DEF_PB_EN      = 1'b1,
  parameter bit DEF_BLACK_SEQ  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSync,
  input  logic              vSync,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  output logic              clampWin,
  output logic              pixBlank,
  output logic              hClkBlank,
  output logic [1:0]        lineRegion,
  output logic [PIX_W-1:0]  pixIndex
);

  logic [NUM_PIX_FIELDS-1:0][PIX_W-1:0]   activePix;
  logic [NUM_LINE_FIELDS-1:0][LINE_W-1:0] activeLines;
  logic                                   activePbEn;
  logic                                   activeBlackSeq;
  logic                                   frameStart;
  seqStrobes_t                            strobes;

  ccd_seq_regs #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .DATA_W(DATA_W),
    .DEF_VSHIFT(DEF_VSHIFT), .DEF_DUMMY(DEF_DUMMY), .DEF_LEAD_PIX(DEF_LEAD_PIX),
    .DEF_EFF_PIX(DEF_EFF_PIX), .DEF_TRAIL_PIX(DEF_TRAIL_PIX),
    .DEF_LEAD_LINES(DEF_LEAD_LINES), .DEF_EFF_LINES(DEF_EFF_LINES),
    .DEF_PB_EN(DEF_PB_EN), .DEF_BLACK_SEQ(DEF_BLACK_SEQ)
  ) uRegs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .frameStart(frameStart), .activePix(activePix), .activeLines(activeLines),
    .activePbEn(activePbEn), .activeBlackSeq(activeBlackSeq)
  );

  ccd_seq_ctrl #(.LINE_W(LINE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .hSync(hSync), .vSync(vSync),
    .leadLines(activeLines[FL_LEAD]), .effLines(activeLines[FL_EFF]),
    .blackSeqEn(activeBlackSeq), .frameStart(frameStart), .strobes(strobes)
  );

  ccd_seq_datapath #(.PIX_W(PIX_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .activePix(activePix),
    .pbEn(activePbEn), .clampWin(clampWin), .pixBlank(pixBlank),
    .hClkBlank(hClkBlank), .lineRegion(lineRegion), .pixIndex(pixIndex)
  );

endmodule

// File: tb/sim_ccd_line_sequencer.sv
module sim_ccd_line_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_W      = 8;
  localparam int LINE_W     = 6;
  localparam int DATA_W     = 16;

  logic              clk = 1'b0;
  logic              rstN;
  logic              hSync;
  logic              vSync;
  logic              cfgWe;
  logic [2:0]        cfgAddr;
  logic [DATA_W-1:0] cfgData;
  logic              clampWin;
  logic              pixBlank;
  logic              hClkBlank;
  logic [1:0]        lineRegion;
  logic [PIX_W-1:0]  pixIndex;

  int nChecks = 0;
  int nFail   = 0;

  // Bench model of the configuration: active and shadow copies
  int mPix[5];
  int sPix[5];
  int mLead, mEff, sLead, sEff;
  int mPb, mBlk, sPb, sBlk;
  int lineIdx;
  int pending;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_line_sequencer #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .DATA_W(DATA_W),
    .DEF_VSHIFT(3), .DEF_DUMMY(28), .DEF_LEAD_PIX(4), .DEF_EFF_PIX(100),
    .DEF_TRAIL_PIX(48), .DEF_LEAD_LINES(10), .DEF_EFF_LINES(40),
    .DEF_PB_EN(1'b1), .DEF_BLACK_SEQ(1'b0)
  ) u0 (
    .clk(clk), .rstN(rstN), .hSync(hSync), .vSync(vSync), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .clampWin(clampWin), .pixBlank(pixBlank),
    .hClkBlank(hClkBlank), .lineRegion(lineRegion), .pixIndex(pixIndex)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFail++;
    $display("FAIL R1 watchdog expired: actual running, expected finished");
    summary();
    $finish;
  end

  task automatic writeReg(input int addr, input int data);
    cfgWe   = 1'b1;
    cfgAddr = 3'(addr);
    cfgData = DATA_W'(data);
    @(posedge clk);
    @(negedge clk);
    cfgWe = 1'b0;
    if (addr < 5)       sPix[addr] = data & 8'hFF;
    else if (addr == 5) sLead = data & 6'h3F;
    else if (addr == 6) sEff = data & 6'h3F;
    else begin
      sPb  = data & 1;
      sBlk = (data >> 1) & 1;
    end
  endtask

  task automatic writeCfg(input int v, input int d, input int l, input int e, input int t,
                          input int ll, input int el, input int ctrl);
    writeReg(0, v); writeReg(1, d); writeReg(2, l); writeReg(3, e);
    writeReg(4, t); writeReg(5, ll); writeReg(6, el); writeReg(7, ctrl);
  endtask

  // Frame start: applies the shadow configuration
  task automatic frameSync();
    vSync = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vSync = 1'b0;
    for (int i = 0; i < 5; i++) mPix[i] = sPix[i];
    mLead = sLead; mEff = sEff; mPb = sPb; mBlk = sBlk;
    pending = 1;
  endtask

  task automatic startLine();
    hSync = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkPix(input int k, input string phase);
    int reg_, acc, expLr, blackLine, useB;
    logic expH, expP, expC;
    string req;
    reg_ = 5;
    acc  = 0;
    for (int i = 0; i < 5; i++) begin
      acc += mPix[i];
      if (reg_ == 5 && k < acc) reg_ = i;
    end
    expLr     = (lineIdx < mLead) ? 0 : (lineIdx < mLead + mEff) ? 1 : 2;
    blackLine = (expLr != 1);
    useB      = blackLine && mBlk;
    expH      = (reg_ == 0);
    expP      = mPb && reg_ != 3 && reg_ != 5;
    expC      = useB ? (reg_ >= 1 && reg_ <= 4) : (reg_ == 4);
    nChecks++;
    if (pixIndex !== PIX_W'(k) || lineRegion !== 2'(expLr) || hClkBlank !== expH ||
        pixBlank !== expP || clampWin !== expC) begin
      if (pixIndex !== PIX_W'(k))         req = "R1";
      else if (lineRegion !== 2'(expLr))  req = "R8";
      else if (reg_ == 5)                 req = "R6";
      else if (hClkBlank !== expH)        req = "R2";
      else if (pixBlank !== expP)         req = mPb ? "R2" : "R3";
      else if (useB)                      req = "R4";
      else if (blackLine)                 req = "R5";
      else                                req = "R2";
      nFail++;
      $display("FAIL %s [%s] line %0d pixel %0d: actual h=%b p=%b c=%b reg=%0d idx=%0d expected h=%b p=%b c=%b reg=%0d idx=%0d",
               req, phase, lineIdx, k, hClkBlank, pixBlank, clampWin, lineRegion, pixIndex,
               expH, expP, expC, expLr, k);
    end
  endtask

  // Precondition: the edge just passed sampled hSync high
  task automatic runLine(input int len, input bit chain, input string phase);
    hSync = 1'b0;
    if (pending != 0) begin
      pending = 0;
      lineIdx = 0;
    end else if (lineIdx < 63) begin
      lineIdx++;
    end
    for (int k = 0; k < len; k++) begin
      @(posedge clk);
      @(negedge clk);
      checkPix(k, phase);
      if (chain && k == len - 2) hSync = 1'b1;
    end
  endtask

  initial begin
    rstN = 1'b0; hSync = 1'b0; vSync = 1'b0;
    cfgWe = 1'b0; cfgAddr = '0; cfgData = '0;
    mPix[0] = 3; mPix[1] = 28; mPix[2] = 4; mPix[3] = 100; mPix[4] = 48;
    mLead = 10; mEff = 40; mPb = 1; mBlk = 0;
    for (int i = 0; i < 5; i++) sPix[i] = mPix[i];
    sLead = mLead; sEff = mEff; sPb = mPb; sBlk = mBlk;
    lineIdx = 0; pending = 1;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    nChecks++;
    if ({clampWin, pixBlank, hClkBlank} !== 3'b000 || lineRegion !== 2'd0 || pixIndex !== '0) begin
      nFail++;
      $display("FAIL R10 reset: actual c/p/h=%b%b%b reg=%0d idx=%0d expected 000 reg=0 idx=0",
               clampWin, pixBlank, hClkBlank, lineRegion, pixIndex);
    end
    rstN = 1'b1;

    // R6: idle after reset, before any line start
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      nChecks++;
      if ({clampWin, pixBlank, hClkBlank} !== 3'b000 || lineRegion !== 2'd0) begin
        nFail++;
        $display("FAIL R6 idle after reset: actual c/p/h=%b%b%b reg=%0d expected 000 reg=0",
                 clampWin, pixBlank, hClkBlank, lineRegion);
      end
    end

    // R9: new values wait in shadow; this line still runs on the defaults
    writeCfg(2, 3, 2, 5, 4, 2, 3, 3);
    startLine();
    runLine(20, 1'b0, "R9 defaults before frame start");

    // Config A applied: blanking on, black-line sequence on (R2, R4, R8)
    frameSync();
    startLine();
    for (int ln = 0; ln < 7; ln++) runLine(20, ln < 6, "R4 frame A");

    // R9: config B written mid-frame; the next line still uses A
    writeCfg(1, 2, 1, 6, 3, 1, 4, 0);
    startLine();
    runLine(20, 1'b0, "R9 shadow pending");

    // Config B: blanking off (R3), black lines share effective timing (R5)
    frameSync();
    startLine();
    for (int ln = 0; ln < 7; ln++) runLine(20, ln < 6, "R5 frame B");

    // R7: lines cut short under config A (total 16 pixels)
    writeCfg(2, 3, 2, 5, 4, 2, 3, 3);
    frameSync();
    startLine();
    for (int ln = 0; ln < 6; ln++) runLine((ln % 2 == 0) ? 14 : 9, ln < 5, "R7 truncated");

    summary();
    $finish;
  end

endmodule